// File: doc/BRIEF.md
# Oversampled Serial Character Receiver with Error-Tagged Queue

This block recovers characters from an asynchronous serial line. A one-cycle enable pulse arrives at sixteen times the bit rate. The line input passes through a two-flop synchroniser. Each bit is then sampled once, near its centre. The host sets the character length, the parity mode and the stop-bit count through static configuration inputs.

Every completed character is stored together with three flags: parity error, framing error and break. After reset the block is in character mode, where only one holding register is used. When the host sets `fifo_en`, a queue of `DEPTH` entries takes the place of the holding register. The host takes characters from the head of the store with a pop strobe. The receiver raises a data interrupt request and a line-condition interrupt request.

Top module: `serial_rx_core`

## Requirements
- R1: With `fifo_en`=1 the store keeps up to `DEPTH` (16) characters and returns them oldest first. Each entry carries its data byte and its parity, framing and break flags.
- R2: Reset leaves the block in character mode (`fifo_en`=0), where at most one character is held. Any change of `fifo_en` empties the store.
- R3: `cfg_len` selects 5, 6, 7 or 8 data bits for the codes 0, 1, 2 and 3. Bits arrive least significant first, and the unused upper bits of `rd_data` read as zero.
- R4: With `cfg_par_en`=1 a parity bit follows the data. `cfg_par_odd`=0 selects even parity and 1 selects odd parity. A mismatch sets the entry's `rd_pe`.
- R5: `cfg_stop` codes 0, 1 and 2 (3 acts as 2) select 1, 1.5 or 2 stop bits. Only the first stop bit is sampled. If that sample is low, `rd_fe` is set, and the receiver waits for the line to return high before it looks for a new start bit.
- R6: A falling edge whose level is high again at the 8th oversample tick is a false start. It is discarded and stores nothing.
- R7: A character that completes while the store is full sets `overrun`. In FIFO mode the new character is dropped. In character mode it replaces the held one. `overrun` stays set until `ovr_clr` is pulsed.
- R8: A line that is low through the start, data, parity and first stop samples produces a single entry with data 0, `rd_brk`=1, `rd_fe`=1 and `rd_pe`=0. No further entry follows until the line has gone high.
- R9: `data_rdy` is high while the store holds at least one entry. A `rd_pop` while `data_rdy` is high removes the head entry together with its flags.
- R10: In character mode `irq_rx` equals `data_rdy`. In FIFO mode `irq_rx` is high when the fill level reaches the threshold chosen by `cfg_trig`: codes 0, 1, 2 and 3 select 1, DEPTH/4, DEPTH/2 and DEPTH-2 entries.
- R11: `irq_line` is high when `overrun` is set, or when the store is not empty and its head entry has any error flag set.
- R12: After reset `data_rdy`, `overrun`, `irq_rx` and `irq_line` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick16 | input | 1 | Oversample enable, 16 pulses per bit |
| rxd | input | 1 | Serial line, idle high |
| fifo_en | input | 1 | 1 = queue mode, 0 = single holding register |
| cfg_len | input | 2 | Character length code (5 to 8 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_stop | input | 2 | Stop-bit code |
| cfg_trig | input | 2 | FIFO interrupt threshold code |
| rd_pop | input | 1 | Remove head entry |
| ovr_clr | input | 1 | Clear the overrun flag |
| rd_data | output | 8 | Head entry data |
| rd_pe | output | 1 | Head entry parity error |
| rd_fe | output | 1 | Head entry framing error |
| rd_brk | output | 1 | Head entry break |
| data_rdy | output | 1 | Store not empty |
| overrun | output | 1 | Sticky overrun flag |
| irq_rx | output | 1 | Receive data interrupt request |
| irq_line | output | 1 | Line condition interrupt request |

## Verification
The bench builds the block with its default values, DEPTH of 16 and 16 oversample ticks per bit, and pulses `tick16` every second clock. A 16-entry store is shallow enough that random bursts of up to 19 characters regularly overrun it. The same depth makes all four interrupt thresholds (1, 4, 8 and 14 entries) reachable. Sixteen ticks per bit keeps each frame to a few hundred clocks, so every combination of length, parity and stop count, with injected parity and framing faults, fits in the cycle budget.

// File: rtl/rxq_pkg.sv
// Shared types for the serial character receiver.
// Assumes: data bytes are at most 8 bits wide.
package rxq_pkg;

    // One stored character with its three condition flags.
    typedef struct packed {
        logic       brk;
        logic       fe;
        logic       pe;
        logic [7:0] data;
    } rx_entry_t;

    // Receiver framing states.
    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PAR,
        S_STOP,
        S_XSTOP,
        S_WAITHI
    } rx_state_t;

endpackage

// File: rtl/rx_sync.sv
// Multi-flop synchroniser for the asynchronous serial line.
// Assumes: STAGES >= 2; the line idles high, so the flops reset to 1.
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    // Shift the raw line through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/rx_frame.sv
// Character framing engine: start validation, mid-bit sampling,
// parity, stop and break evaluation. Pulses push for one clock with
// the finished entry.
// Assumes: rx is already synchronised; the config is stable during a frame.
module rx_frame
    import rxq_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      rx,
    input  logic [1:0] cfg_len,
    input  logic      cfg_par_en,
    input  logic      cfg_par_odd,
    input  logic [1:0] cfg_stop,
    output logic      push,
    output rx_entry_t entry
);
    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] HALF_M1 = CW'(OSR/2 - 1);
    localparam logic [CW-1:0] FULL_M1 = CW'(OSR - 1);

    rx_state_t     state;
    logic [CW-1:0] cnt;
    logic [2:0]    bit_idx;
    logic [7:0]    shreg;
    logic          par_acc;
    logic          zero_acc;
    logic [3:0]    nbits;
    logic [CW-1:0] x_last;
    logic          brk_now;

    assign nbits   = 4'd5 + {2'b00, cfg_len};
    assign x_last  = (cfg_stop == 2'd1) ? HALF_M1 : FULL_M1;
    assign brk_now = zero_acc & ~rx;

    // Frame state machine, advanced on oversample ticks only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            cnt      <= '0;
            bit_idx  <= '0;
            shreg    <= '0;
            par_acc  <= 1'b0;
            zero_acc <= 1'b0;
            push     <= 1'b0;
            entry    <= '0;
        end else begin
            push <= 1'b0;
            if (tick) begin
                unique case (state)
                    S_IDLE: if (!rx) begin
                        state <= S_START;
                        cnt   <= CW'(1);
                    end
                    S_START: if (cnt == HALF_M1) begin
                        cnt      <= '0;
                        bit_idx  <= '0;
                        shreg    <= '0;
                        par_acc  <= 1'b0;
                        zero_acc <= 1'b1;
                        state    <= rx ? S_IDLE : S_DATA;
                    end else cnt <= cnt + 1'b1;
                    S_DATA: if (cnt == FULL_M1) begin
                        cnt      <= '0;
                        shreg    <= {rx, shreg[7:1]};
                        par_acc  <= par_acc ^ rx;
                        zero_acc <= zero_acc & ~rx;
                        if ({1'b0, bit_idx} == nbits - 4'd1)
                            state <= cfg_par_en ? S_PAR : S_STOP;
                        else
                            bit_idx <= bit_idx + 1'b1;
                    end else cnt <= cnt + 1'b1;
                    S_PAR: if (cnt == FULL_M1) begin
                        cnt      <= '0;
                        par_acc  <= par_acc ^ rx;
                        zero_acc <= zero_acc & ~rx;
                        state    <= S_STOP;
                    end else cnt <= cnt + 1'b1;
                    S_STOP: if (cnt == FULL_M1) begin
                        cnt        <= '0;
                        push       <= 1'b1;
                        entry.brk  <= brk_now;
                        entry.fe   <= ~rx;
                        entry.pe   <= ~brk_now & cfg_par_en & (par_acc ^ cfg_par_odd);
                        entry.data <= brk_now ? 8'h00 : (shreg >> (4'd8 - nbits));
                        if (!rx)                  state <= S_WAITHI;
                        else if (cfg_stop == 2'd0) state <= S_IDLE;
                        else                      state <= S_XSTOP;
                    end else cnt <= cnt + 1'b1;
                    S_XSTOP: if (cnt == x_last) begin
                        cnt   <= '0;
                        state <= S_IDLE;
                    end else cnt <= cnt + 1'b1;
                    S_WAITHI: if (rx) state <= S_IDLE;
                    default: state <= S_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/rx_store.sv
// Character store: a DEPTH-entry queue in FIFO mode, or a single
// holding register (entry 0) in character mode. Owns the overrun flag.
// Assumes: a change of fifo_en flushes the contents.
module rx_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       fifo_en,
    input  logic                       push,
    input  rx_entry_t                  wentry,
    input  logic                       pop,
    input  logic                       ovr_clr,
    output rx_entry_t                  head,
    output logic [$clog2(DEPTH):0]     occ,
    output logic                       ovr
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0]   FULL = (AW+1)'(DEPTH);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    rx_entry_t       mem [DEPTH];
    logic [AW-1:0]   rd_ptr, wr_ptr;
    logic            mode_q;
    logic            flush, do_pop, full, wr_en;
    logic [AW-1:0]   wr_addr;

    assign flush   = (mode_q != fifo_en);
    assign do_pop  = pop && (occ != '0);
    assign full    = fifo_en ? (occ == FULL) : (occ != '0);
    assign wr_en   = !flush && push && (!fifo_en || !full || do_pop);
    assign wr_addr = fifo_en ? wr_ptr : '0;
    assign head    = mem[rd_ptr];

    // Entry storage write port.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wentry;
    end

    // Pointers, fill level, mode tracking and overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            occ    <= '0;
            mode_q <= 1'b0;
            ovr    <= 1'b0;
        end else if (flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            occ    <= '0;
            mode_q <= fifo_en;
        end else begin
            if (ovr_clr) ovr <= 1'b0;
            if (push && full && !do_pop) ovr <= 1'b1;
            if (!fifo_en) begin
                if (push)        occ <= (AW+1)'(1);
                else if (do_pop) occ <= '0;
            end else begin
                if (wr_en)  wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
                if (do_pop) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
                if (wr_en && !do_pop)      occ <= occ + 1'b1;
                else if (!wr_en && do_pop) occ <= occ - 1'b1;
            end
        end
    end
endmodule

// File: rtl/serial_rx_core.sv
// Top of the serial character receiver: synchroniser, framing engine,
// character store and interrupt request logic.
// Assumes: tick16 is a one-clock pulse at OSR times the bit rate.
module serial_rx_core
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int OSR   = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic       rxd,
    input  logic       fifo_en,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic [1:0] cfg_stop,
    input  logic [1:0] cfg_trig,
    input  logic       rd_pop,
    input  logic       ovr_clr,
    output logic [7:0] rd_data,
    output logic       rd_pe,
    output logic       rd_fe,
    output logic       rd_brk,
    output logic       data_rdy,
    output logic       overrun,
    output logic       irq_rx,
    output logic       irq_line
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] TRIG_A = (AW+1)'(1);
    localparam logic [AW:0] TRIG_B = (AW+1)'(DEPTH / 4);
    localparam logic [AW:0] TRIG_C = (AW+1)'(DEPTH / 2);
    localparam logic [AW:0] TRIG_D = (AW+1)'(DEPTH - 2);

    logic        rx_s;
    logic        push;
    rx_entry_t   wentry, head;
    logic [AW:0] occ;
    logic [AW:0] trig_lvl;

    rx_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(rxd), .q(rx_s)
    );

    rx_frame #(.OSR(OSR)) u_frame (
        .clk(clk), .rst_n(rst_n), .tick(tick16), .rx(rx_s),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_stop(cfg_stop), .push(push), .entry(wentry)
    );

    rx_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .push(push),
        .wentry(wentry), .pop(rd_pop), .ovr_clr(ovr_clr),
        .head(head), .occ(occ), .ovr(overrun)
    );

    // Select the FIFO interrupt threshold.
    always_comb begin
        unique case (cfg_trig)
            2'd0:    trig_lvl = TRIG_A;
            2'd1:    trig_lvl = TRIG_B;
            2'd2:    trig_lvl = TRIG_C;
            default: trig_lvl = TRIG_D;
        endcase
    end

    assign data_rdy = (occ != '0);
    assign rd_data  = head.data;
    assign rd_pe    = head.pe;
    assign rd_fe    = head.fe;
    assign rd_brk   = head.brk;
    assign irq_rx   = fifo_en ? (occ >= trig_lvl) : data_rdy;
    assign irq_line = overrun | (data_rdy & (head.pe | head.fe | head.brk));
endmodule

// File: rtl/serial_rx_core_chk.sv
// Property checker for serial_rx_core, attached with bind below.
// Assumes: it sees the store fill level and the framing push strobe.
module serial_rx_core_chk #(
    parameter int DEPTH = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   fifo_en,
    input logic                   rd_pop,
    input logic                   ovr_clr,
    input logic                   push,
    input logic [$clog2(DEPTH):0] occ,
    input logic                   data_rdy,
    input logic                   overrun,
    input logic [7:0]             rd_data,
    input logic                   rd_brk,
    input logic                   rd_fe
);
    assert_fifo_cap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= ($clog2(DEPTH)+1)'(DEPTH));

    assert_char_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && !$past(fifo_en)) |-> occ <= 1);

    assert_ovr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovr_clr && fifo_en == $past(fifo_en)) |=> overrun);

    assert_ovr_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && fifo_en && fifo_en == $past(fifo_en) && !rd_pop &&
         occ == ($clog2(DEPTH)+1)'(DEPTH)) |=> overrun);

    assert_brk_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rdy && rd_brk) |-> (rd_data == 8'h00 && rd_fe));

    assert_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pop && data_rdy && !push && fifo_en && fifo_en == $past(fifo_en))
        |=> occ == $past(occ) - 1'b1);
endmodule

bind serial_rx_core serial_rx_core_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rd_pop(rd_pop),
    .ovr_clr(ovr_clr), .push(push), .occ(occ), .data_rdy(data_rdy),
    .overrun(overrun), .rd_data(rd_data), .rd_brk(rd_brk), .rd_fe(rd_fe)
);

// File: tb/serial_rx_core_test.sv
// Self-checking bench: random traffic against a queue model plus directed corners.
module serial_rx_core_test;
    localparam int DEPTH = 16;
    localparam int OSR   = 16;
    localparam int TD    = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16;
    logic       rxd = 1'b1;
    logic       fifo_en = 1'b0;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic [1:0] cfg_stop = 2'd0;
    logic [1:0] cfg_trig = 2'd0;
    logic       rd_pop = 1'b0;
    logic       ovr_clr = 1'b0;
    logic [7:0] rd_data;
    logic       rd_pe, rd_fe, rd_brk, data_rdy, overrun, irq_rx, irq_line;

    int checks = 0;
    int fails  = 0;
    logic [10:0] exp_q[$];
    bit m_ovr = 1'b0;
    int tdiv = 0;

    serial_rx_core #(.DEPTH(DEPTH), .OSR(OSR)) uut (.*);

    always #10 clk = ~clk;

    // Oversample enable every TD clocks.
    always_ff @(posedge clk) tdiv <= (tdiv == TD-1) ? 0 : tdiv + 1;
    assign tick16 = (tdiv == 0);

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int ticks);
        rxd = v;
        repeat (ticks * TD) @(negedge clk);
    endtask

    function automatic logic [7:0] lenmask(input int len);
        logic [7:0] m;
        for (int i = 0; i < 8; i++) m[i] = (i < len);
        return m;
    endfunction

    // Expected entry {brk, fe, pe, data} for a normal (non-break) frame.
    function automatic logic [10:0] exp_entry(input logic [7:0] d, input int len,
                                              input bit pen, input bit bad_par, input bit bad_stop);
        return {1'b0, bad_stop, pen & bad_par, d & lenmask(len)};
    endfunction

    // Queue model: drop on full in FIFO mode, overwrite in character mode.
    task automatic model_push(input logic [10:0] e);
        if (fifo_en) begin
            if (exp_q.size() < DEPTH) exp_q.push_back(e);
            else m_ovr = 1'b1;
        end else begin
            if (exp_q.size() > 0) begin m_ovr = 1'b1; exp_q[0] = e; end
            else exp_q.push_back(e);
        end
    endtask

    task automatic send(input logic [7:0] d, input bit bad_par, input bit bad_stop);
        int len;
        logic p;
        len = 5 + int'(cfg_len);
        hold(1'b0, OSR);
        for (int i = 0; i < len; i++) hold(d[i], OSR);
        if (cfg_par_en) begin
            p = (^(d & lenmask(len))) ^ cfg_par_odd ^ bad_par;
            hold(p, OSR);
        end
        if (bad_stop) begin
            hold(1'b0, OSR);
            hold(1'b1, OSR);
        end else begin
            hold(1'b1, (cfg_stop == 2'd0) ? OSR : (cfg_stop == 2'd1) ? OSR + OSR/2 : 2*OSR);
        end
        model_push(exp_entry(d, len, cfg_par_en, bad_par, bad_stop));
    endtask

    function automatic int trig_level(input logic [1:0] t);
        case (t)
            2'd0: return 1;
            2'd1: return DEPTH/4;
            2'd2: return DEPTH/2;
            default: return DEPTH-2;
        endcase
    endfunction

    // Read the head entry and compare it with the model (R1 R3 R4 R5 R9).
    task automatic read_check(input string tag);
        logic [10:0] e;
        e = exp_q.pop_front();
        chk(data_rdy == 1'b1, {tag, " R9 ready"}, 32'(data_rdy), 32'd1);
        chk({rd_brk, rd_fe, rd_pe, rd_data} == e, tag, 32'({rd_brk, rd_fe, rd_pe, rd_data}), 32'(e));
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_mode(input bit fm);
        fifo_en = ~fm;
        repeat (3) @(negedge clk);
        fifo_en = fm;
        ovr_clr = 1'b1;
        repeat (3) @(negedge clk);
        ovr_clr = 1'b0;
        exp_q.delete();
        m_ovr = 1'b0;
    endtask

    task automatic check_flags(input string tag);
        bit eline;
        bit erx;
        eline = m_ovr || (exp_q.size() > 0 && exp_q[0][10:8] != 3'b000);
        erx   = fifo_en ? (exp_q.size() >= trig_level(cfg_trig)) : (exp_q.size() > 0);
        chk(overrun == m_ovr, {tag, " R7 overrun"}, 32'(overrun), 32'(m_ovr));
        chk(irq_rx == erx, {tag, " R10 irq_rx"}, 32'(irq_rx), 32'(erx));
        chk(irq_line == eline, {tag, " R11 irq_line"}, 32'(irq_line), 32'(eline));
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R12: actual timeout expected completion");
        report();
    end

    initial begin
        int unsigned r;
        r = $urandom(32'd7351);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state
        chk(data_rdy == 1'b0, "R12 data_rdy", 32'(data_rdy), 32'd0);
        chk(overrun == 1'b0, "R12 overrun", 32'(overrun), 32'd0);
        chk(irq_rx == 1'b0, "R12 irq_rx", 32'(irq_rx), 32'd0);
        chk(irq_line == 1'b0, "R12 irq_line", 32'(irq_line), 32'd0);

        // R2 R7: character mode after reset, second character overwrites
        hold(1'b1, OSR);
        send(8'hA5, 1'b0, 1'b0);
        send(8'h3C, 1'b0, 1'b0);
        check_flags("R2 char mode");
        read_check("R2 holding register");
        chk(data_rdy == 1'b0, "R2 single entry", 32'(data_rdy), 32'd0);
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        @(negedge clk);
        chk(overrun == 1'b0, "R7 ovr_clr", 32'(overrun), 32'd0);
        m_ovr = 1'b0;

        // R6: false start then a good character
        hold(1'b0, 5);
        hold(1'b1, 3*OSR);
        chk(data_rdy == 1'b0, "R6 false start stored nothing", 32'(data_rdy), 32'd0);
        send(8'h81, 1'b0, 1'b0);
        read_check("R6 after false start");

        // R8: long break gives one entry; R11 line interrupt
        set_mode(1'b1);
        cfg_par_en = 1'b1; cfg_par_odd = 1'b1; cfg_len = 2'd3;
        hold(1'b0, 3*12*OSR);
        hold(1'b1, 2*OSR);
        exp_q.push_back(11'b110_0000_0000);
        chk(irq_line == 1'b1, "R11 break irq_line", 32'(irq_line), 32'd1);
        read_check("R8 break entry");
        chk(data_rdy == 1'b0, "R8 single break entry", 32'(data_rdy), 32'd0);

        // R10: threshold DEPTH/4
        cfg_par_en = 1'b0; cfg_trig = 2'd1;
        for (int i = 0; i < DEPTH/4 - 1; i++) send(8'(i + 1), 1'b0, 1'b0);
        chk(irq_rx == 1'b0, "R10 below threshold", 32'(irq_rx), 32'd0);
        send(8'h55, 1'b0, 1'b0);
        chk(irq_rx == 1'b1, "R10 at threshold", 32'(irq_rx), 32'd1);

        // R2: mode change flushes
        fifo_en = 1'b0;
        repeat (3) @(negedge clk);
        chk(data_rdy == 1'b0, "R2 flush on mode change", 32'(data_rdy), 32'd0);
        exp_q.delete();

        // Random traffic: R1 R3 R4 R5 R7 R10 R11
        for (int t = 0; t < 24; t++) begin
            int k;
            r = $urandom();
            set_mode(r[0]);
            cfg_len = r[2:1]; cfg_par_en = r[3]; cfg_par_odd = r[4];
            cfg_stop = r[6:5]; cfg_trig = r[8:7];
            k = fifo_en ? int'($urandom_range(1, DEPTH + 3)) : int'($urandom_range(1, 2));
            for (int i = 0; i < k; i++) begin
                logic [7:0] d;
                bit bp, bs;
                r = $urandom();
                d  = r[7:0];
                bp = cfg_par_en && (r[10:8] == 3'd0);
                bs = (r[13:11] == 3'd1);
                if (bs) d[0] = 1'b1;
                send(d, bp, bs);
            end
            check_flags("random");
            while (exp_q.size() > 0) read_check("R1 R3 R4 R5 random entry");
            chk(data_rdy == 1'b0, "R9 drained", 32'(data_rdy), 32'd0);
        end

        report();
    end
endmodule